// File: doc/BRIEF.md
# PLL multiplier code converter

This block translates between a plain binary PLL feedback multiplier and the scrambled code that a feedback divider built around a 15-bit shift register expects. In the encode direction it takes a multiplier from 0 to 32768. It produces the divider code by stepping the shift register away from a fixed start state. It also computes the proportional and integral loop-bandwidth selects from the same multiplier and returns all three packed into one control word. In the decode direction it takes a code and steps the register back towards the start state while counting down. The count left when the start state is reached is the multiplier.

A request is one accepted `start_i` pulse carrying a direction flag and a 17-bit value. The block is busy while it walks, one register step per clock. It ends the request with a single-cycle `done_o`, and the result stays on `result_o` until the next completion. Multipliers 0, 1 and 2 use fixed codes and finish without walking. A code that collapses to the all-zero register state can never reach the start state, so it is reported as invalid.

Top module: `mdc_codec`

## Requirements
- R1: With `dir_i`=0 (encode), multiplier 0 gives code 0x00000, multiplier 1 gives 0x18003 and multiplier 2 gives 0x10003. No walk is made, so `done_o` is high in the second cycle after the accepting edge.
- R2: For an encode of multiplier m with 3 ≤ m ≤ 32768, the register starts at 0x4000 and takes 32769−m steps of next = ({x[16:1]}) with bit 14 additionally set to x[0]^x[1]. One step is taken per clock, and `done_o` is high in cycle 32769−m+2 counted from the accepting edge.
- R3: With `dir_i`=1 (decode), code 0x18003 returns 1 and code 0x10003 returns 2, with no walk.
- R4: For any other decode, a counter starts at 32769 and the register starts at the code. Each step applies next[14:0] = {x[13:0], x[0]^x[14]} with the upper two bits cleared, and decrements the counter. The walk ends when the register equals 0x4000, and the counter value is the result. A code produced by encoding m decodes back to m in 32769−m steps, and code 0x4000 decodes to 32769 with no step.
- R5: A decode whose register is, or becomes, all-zero ends at once with result 0 and `invalid_o` high during the `done_o` cycle only. The same happens when the counter reaches 0 away from 0x4000.
- R6: An encode result packs the code in `result_o`[16:0], the proportional select in [21:17] and the integral select in [27:22]. A decode result carries the multiplier in [16:0] with [27:17] zero.
- R7: The proportional select is (m>>1)+1 for m < 60 and 31 otherwise.
- R8: The integral select is 1 for m > 16384, 2 for m > 8192, 4 for m > 2048 and 8 for m ≥ 501.
- R9: For 60 ≤ m ≤ 500, the integral select is 4·t with t = floor(1024/(m+9)) when that division leaves a remainder, and 4·(t+1) when it is exact.
- R10: For m < 60, the integral select is (m & 0x3C) + 4.
- R11: `start_i` is ignored while `busy_o` is high. `done_o` lasts exactly one cycle, `busy_o` is high from the edge after acceptance through the `done_o` cycle, and `result_o` changes only in a `done_o` cycle.
- R12: After reset, `busy_o`, `done_o`, `invalid_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| dir_i | input | 1 | 0 = encode a multiplier, 1 = decode a code |
| value_i | input | 17 | Multiplier (encode) or divider code (decode) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Decode could not reach the start state; valid with done_o |
| result_o | output | 28 | Packed control word (encode) or multiplier (decode) |

## Verification
A wrong feedback tap or shift direction shows as a wrong code or multiplier when `done_o` rises. A miscounted step or bound shows as `done_o` arriving a cycle early or late, or as a result off by one. Both show on the first request that walks, after 32769−m steps plus two cycles. A bandwidth threshold or divide error appears only in the packed fields, and only for multipliers on its side of the boundary. The bench therefore places directed multipliers in each range and at the exact-division case, and compares every whole word and every latency with its own model.

// File: rtl/mdc_pkg.sv
// Shared constants and types for the multiplier code converter.
// Assumes a 15-bit feedback register with codes carried in 17 bits.
package mdc_pkg;
    localparam int STATE_W = 15;
    localparam int CODE_W  = STATE_W + 2;
    localparam int MSEL_W  = STATE_W + 2;
    localparam int SELP_W  = 5;
    localparam int SELI_W  = 6;
    localparam int WORD_W  = CODE_W + SELP_W + SELI_W;

    localparam logic [CODE_W-1:0] SEED     = CODE_W'(1) << (STATE_W - 1);
    localparam logic [CODE_W-1:0] CODE_ONE = 17'h18003;
    localparam logic [CODE_W-1:0] CODE_TWO = 17'h10003;
    localparam logic [MSEL_W-1:0] MSEL_MAX = MSEL_W'(1) << STATE_W;
    localparam logic [MSEL_W-1:0] CNT_TOP  = MSEL_MAX + MSEL_W'(1);

    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} fsm_t;
    typedef enum logic {DIR_ENC = 1'b0, DIR_DEC = 1'b1} dir_t;
endpackage

// File: rtl/mdc_walk.sv
// Shift-register walker: holds the code state and the step counter.
// Encode steps shift right with feedback into the top state bit and count up;
// decode steps shift left with feedback into bit 0 and count down.
// Assumes the controller asserts step_i only between load and completion.
module mdc_walk
    import mdc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = MSEL_W,
    parameter int SW = STATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  dir_t          dir_i,
    input  logic [CW-1:0] load_state_i,
    input  logic [NW-1:0] load_cnt_i,
    output logic [CW-1:0] state_o,
    output logic [NW-1:0] cnt_o
);
    logic [CW-1:0] state_q;
    logic [NW-1:0] cnt_q;
    logic [CW-1:0] enc_next;
    logic [CW-1:0] dec_next;

    // Next state for both walking directions.
    always_comb begin
        enc_next = {1'b0, state_q[CW-1:1]} | (CW'(state_q[0] ^ state_q[1]) << (SW - 1));
        dec_next = CW'({state_q[SW-2:0], state_q[0] ^ state_q[SW-1]});
    end

    // State and counter registers: load on accept, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            state_q <= load_state_i;
            cnt_q   <= load_cnt_i;
        end else if (step_i) begin
            if (dir_i == DIR_ENC) begin
                state_q <= enc_next;
                cnt_q   <= cnt_q + NW'(1);
            end else begin
                state_q <= dec_next;
                cnt_q   <= cnt_q - NW'(1);
            end
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/mdc_bw_sel.sv
// Loop-bandwidth select derivation from the binary multiplier.
// The mid-range quotient floor(1024/(m+9)) is found by comparing constant
// multiples of (m+9) against 1024, so no divider is built.
// Assumes the multiplier is the plain binary value, never the code.
module mdc_bw_sel
    import mdc_pkg::*;
#(
    parameter int NW     = MSEL_W,
    parameter int PW     = SELP_W,
    parameter int IW     = SELI_W,
    parameter int NUMER  = 1024,
    parameter int OFFSET = 9,
    parameter int LOW_LIM = 60,
    parameter int MID_LIM = 501
) (
    input  logic [NW-1:0] msel_i,
    output logic [PW-1:0] selp_o,
    output logic [IW-1:0] seli_o
);
    localparam int KMAX = NUMER / (LOW_LIM + OFFSET);
    localparam int QW   = $clog2(KMAX + 2);

    logic [31:0]     den;
    logic [KMAX:1]   fits;
    logic [KMAX:1]   exact;
    logic [QW-1:0]   quot;
    logic [QW-1:0]   quot_adj;

    // Divisor for the mid-range rule.
    assign den = 32'(msel_i) + 32'(OFFSET);

    // One comparator pair per candidate quotient value.
    for (genvar k = 1; k <= KMAX; k++) begin : g_cmp
        assign fits[k]  = (32'(k) * den) <= 32'(NUMER);
        assign exact[k] = (32'(k) * den) == 32'(NUMER);
    end

    // Quotient is the number of fitting multiples; bump by one when exact.
    always_comb begin
        quot     = QW'($countones(fits));
        quot_adj = (|exact) ? quot + QW'(1) : quot;
    end

    // Proportional select.
    always_comb begin
        if (msel_i < NW'(LOW_LIM)) selp_o = PW'(msel_i[5:1]) + PW'(1);
        else                       selp_o = PW'(31);
    end

    // Integral select by range.
    always_comb begin
        if (msel_i > NW'(16384))        seli_o = IW'(1);
        else if (msel_i > NW'(8192))    seli_o = IW'(2);
        else if (msel_i > NW'(2048))    seli_o = IW'(4);
        else if (msel_i >= NW'(MID_LIM)) seli_o = IW'(8);
        else if (msel_i >= NW'(LOW_LIM)) seli_o = IW'({quot_adj, 2'b00});
        else                             seli_o = IW'(msel_i[5:0] & 6'h3C) + IW'(4);
    end
endmodule

// File: rtl/mdc_ctrl.sv
// Request controller: accepts a start when idle, runs the walk until its
// end condition, then shows done for one cycle.
// Assumes state_i/cnt_i come from the walker loaded on the accepting edge.
module mdc_ctrl
    import mdc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = MSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dir_i,
    input  logic [CW-1:0] state_i,
    input  logic [NW-1:0] cnt_i,
    output fsm_t          fsm_o,
    output dir_t          dir_o,
    output logic          load_o,
    output logic          step_o,
    output logic          finish_o
);
    fsm_t fsm_q;
    dir_t dir_q;
    logic stop;

    // End condition of the walk for the active direction.
    always_comb begin
        if (dir_q == DIR_ENC) begin
            stop = (cnt_i <= NW'(2)) || (cnt_i > MSEL_MAX);
        end else begin
            stop = (state_i == CODE_ONE) || (state_i == CODE_TWO) ||
                   (state_i == SEED) || (state_i == '0) || (cnt_i == '0);
        end
    end

    // Handshake strobes derived from the state.
    always_comb begin
        load_o   = start_i && (fsm_q == ST_IDLE);
        step_o   = (fsm_q == ST_WALK) && !stop;
        finish_o = (fsm_q == ST_WALK) && stop;
    end

    // State machine and latched direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
            dir_q <= DIR_ENC;
        end else begin
            case (fsm_q)
                ST_IDLE: if (start_i) begin
                    fsm_q <= ST_WALK;
                    dir_q <= dir_t'(dir_i);
                end
                ST_WALK: if (stop) fsm_q <= ST_DONE;
                default: fsm_q <= ST_IDLE;
            endcase
        end
    end

    assign fsm_o = fsm_q;
    assign dir_o = dir_q;
endmodule

// File: rtl/mdc_codec.sv
// Top level of the multiplier code converter. Captures a request, drives the
// walker and controller, forms the packed encode word or the decode result,
// and holds it until the next completion.
// Assumes start_i is a level sampled only while idle.
module mdc_codec
    import mdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [CODE_W-1:0] value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              invalid_o,
    output logic [WORD_W-1:0] result_o
);
    fsm_t              fsm;
    dir_t              op_dir;
    logic              load;
    logic              step;
    logic              finish;
    logic [CODE_W-1:0] state;
    logic [MSEL_W-1:0] cnt;
    logic [CODE_W-1:0] load_state;
    logic [MSEL_W-1:0] load_cnt;
    logic [MSEL_W-1:0] value_q;
    logic [SELP_W-1:0] selp;
    logic [SELI_W-1:0] seli;
    logic [CODE_W-1:0] enc_code;
    logic [MSEL_W-1:0] dec_msel;
    logic              dec_bad;
    logic [WORD_W-1:0] result_q;
    logic              invalid_q;

    // Walker load values per requested direction.
    always_comb begin
        if (dir_i) begin
            load_state = value_i;
            load_cnt   = CNT_TOP;
        end else begin
            load_state = SEED;
            load_cnt   = MSEL_W'(value_i);
        end
    end

    mdc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dir_i    (dir_i),
        .state_i  (state),
        .cnt_i    (cnt),
        .fsm_o    (fsm),
        .dir_o    (op_dir),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish)
    );

    mdc_walk u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .step_i       (step),
        .dir_i        (op_dir),
        .load_state_i (load_state),
        .load_cnt_i   (load_cnt),
        .state_o      (state),
        .cnt_o        (cnt)
    );

    // Request value held for the bandwidth and special-code paths.
    always_ff @(posedge clk) begin
        if (!rst_n)    value_q <= '0;
        else if (load) value_q <= MSEL_W'(value_i);
    end

    mdc_bw_sel u_bw (
        .msel_i (value_q),
        .selp_o (selp),
        .seli_o (seli)
    );

    // Encode code: fixed codes for the three smallest multipliers.
    always_comb begin
        case (value_q)
            MSEL_W'(0): enc_code = '0;
            MSEL_W'(1): enc_code = CODE_ONE;
            MSEL_W'(2): enc_code = CODE_TWO;
            default:    enc_code = state;
        endcase
    end

    // Decode result and validity from the end state of the walk.
    always_comb begin
        dec_bad = 1'b0;
        if (state == CODE_ONE)      dec_msel = MSEL_W'(1);
        else if (state == CODE_TWO) dec_msel = MSEL_W'(2);
        else if (state == SEED)     dec_msel = cnt;
        else begin
            dec_msel = '0;
            dec_bad  = 1'b1;
        end
    end

    // Result registers, written only when a walk finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            invalid_q <= 1'b0;
        end else if (finish) begin
            if (op_dir == DIR_ENC) begin
                result_q  <= {seli, selp, enc_code};
                invalid_q <= 1'b0;
            end else begin
                result_q  <= WORD_W'(dec_msel);
                invalid_q <= dec_bad;
            end
        end
    end

    assign busy_o    = (fsm != ST_IDLE);
    assign done_o    = (fsm == ST_DONE);
    assign invalid_o = done_o && invalid_q;
    assign result_o  = result_q;
endmodule

// File: rtl/mdc_checker.sv
// Port-level protocol checks for the multiplier code converter.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module mdc_checker
    import mdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              dir_i,
    input logic [CODE_W-1:0] value_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              invalid_o,
    input logic [WORD_W-1:0] result_o
);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r11_walk_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r5_invalid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> done_o);

    a_r5_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (result_o == '0));

    a_r1_small_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !dir_i && (value_i <= CODE_W'(2))) |-> ##2 done_o);

    a_r3_special_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && dir_i && ((value_i == CODE_ONE) || (value_i == CODE_TWO)))
        |-> ##2 done_o);

    a_r6_decode_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && invalid_o) |-> (result_o[WORD_W-1:CODE_W] == '0));
endmodule

bind mdc_codec mdc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .dir_i     (dir_i),
    .value_i   (value_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .invalid_o (invalid_o),
    .result_o  (result_o)
);

// File: tb/mdc_codec_tb.sv
module mdc_codec_tb;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [16:0] value_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        invalid_o;
    logic [27:0] result_o;

    int n_checks = 0;
    int n_err = 0;
    int cycle_cnt = 0;
    bit timed_out = 0;

    mdc_codec u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .dir_i (dir_i),
        .value_i (value_i), .busy_o (busy_o), .done_o (done_o),
        .invalid_o (invalid_o), .result_o (result_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycle_cnt <= cycle_cnt + 1;
        if (cycle_cnt == WD_LIMIT + 200) begin
            n_checks++;
            n_err++;
            $display("FAIL R11 watchdog expired actual=%0d expected<%0d", cycle_cnt, WD_LIMIT);
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // Model of the encode walk (R1, R2).
    function automatic logic [16:0] f_enc(input int m);
        int x;
        if (m == 0) return 17'h00000;
        if (m == 1) return 17'h18003;
        if (m == 2) return 17'h10003;
        x = 'h4000;
        for (int i = m; i <= 32768; i++)
            x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hFFFF);
        return 17'(x);
    endfunction

    function automatic int f_enc_steps(input int m);
        if (m <= 2 || m > 32768) return 0;
        return 32769 - m;
    endfunction

    // Model of the decode walk (R3, R4, R5).
    task automatic f_dec(input int code, output int msel, output int steps, output bit inv);
        int x;
        int i;
        steps = 0;
        inv = 0;
        if (code == 'h18003) begin msel = 1; return; end
        if (code == 'h10003) begin msel = 2; return; end
        x = code;
        i = 32769;
        while (x != 'h4000 && x != 0 && i > 0) begin
            x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7FFF);
            i--;
            steps++;
        end
        if (x == 'h4000) msel = i;
        else begin msel = 0; inv = 1; end
    endtask

    function automatic int f_selp(input int m);
        return (m < 60) ? (m >> 1) + 1 : 31;
    endfunction

    function automatic int f_seli(input int m);
        int t;
        if (m > 16384) return 1;
        if (m > 8192) return 2;
        if (m > 2048) return 4;
        if (m >= 501) return 8;
        if (m >= 60) begin
            t = 1024 / (m + 9);
            return (t * (m + 9) == 1024) ? 4 * (t + 1) : 4 * t;
        end
        return (m & 'h3C) + 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One request; optional poke raises start during the walk (must be ignored).
    task automatic do_op(input bit d, input logic [16:0] v, input bit poke,
                         output logic [27:0] res, output bit inv, output int cyc);
        cyc = 0;
        @(negedge clk);
        start_i = 1'b1;
        dir_i = d;
        value_i = v;
        @(posedge clk);
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start_i = 1'b0;
            if (poke && cyc == 3) begin
                start_i = 1'b1;
                dir_i = ~d;
                value_i = 17'h00003;
            end else if (poke && cyc == 4) begin
                start_i = 1'b0;
            end
            if (done_o) break;
            if (cycle_cnt > WD_LIMIT) begin timed_out = 1; break; end
        end
        start_i = 1'b0;
        res = result_o;
        inv = invalid_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R11 done lasts one cycle", 32'(done_o), 32'd0);
    endtask

    task automatic t_enc(input int m, input bit poke, input string tag);
        logic [27:0] r;
        logic [27:0] e;
        bit inv;
        int c;
        e = {6'(f_seli(m)), 5'(f_selp(m)), f_enc(m)};
        do_op(1'b0, 17'(m), poke, r, inv, c);
        chk(r === e, {tag, " R6 encode word"}, 32'(r), 32'(e));
        chk(c == f_enc_steps(m) + 2, {tag, " encode latency"}, 32'(c), 32'(f_enc_steps(m) + 2));
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(result_o === e && !busy_o, "R11 start ignored and result held", 32'(result_o), 32'(e));
        end
    endtask

    task automatic t_dec(input int code, input string tag);
        logic [27:0] r;
        bit inv;
        bit einv;
        int c;
        int em;
        int es;
        f_dec(code, em, es, einv);
        do_op(1'b1, 17'(code), 1'b0, r, inv, c);
        chk(r === 28'(em), {tag, " R6 decode result"}, 32'(r), 32'(em));
        chk(inv == einv, {tag, " invalid flag"}, 32'(inv), 32'(einv));
        chk(c == es + 2, {tag, " decode latency"}, 32'(c), 32'(es + 2));
    endtask

    initial begin
        int seed_dummy;
        int m;
        seed_dummy = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R12 busy after reset", 32'(busy_o), 32'd0);
        chk(done_o == 1'b0, "R12 done after reset", 32'(done_o), 32'd0);
        chk(invalid_o == 1'b0, "R12 invalid after reset", 32'(invalid_o), 32'd0);
        chk(result_o == '0, "R12 result after reset", 32'(result_o), 32'd0);

        t_enc(0, 1'b0, "R1 R7 R10 m=0");
        t_enc(1, 1'b0, "R1 m=1");
        t_enc(2, 1'b0, "R1 m=2");
        t_dec('h18003, "R3 code one");
        t_dec('h10003, "R3 code two");
        t_dec('h04000, "R4 seed code");
        t_dec('h00000, "R5 zero code");
        t_dec('h08000, "R5 code collapsing to zero");
        t_enc(32768, 1'b0, "R2 R8 m=32768");

        t_enc(9000, 1'b1, "R2 R8 m=9000");
        t_enc(2048, 1'b0, "R8 m=2048");
        t_enc(500, 1'b0, "R9 inexact m=500");
        t_enc(247, 1'b0, "R9 exact m=247");
        t_enc(59, 1'b0, "R7 R10 m=59");

        for (int k = 0; k < 20; k++) begin
            m = 32500 + int'($urandom % 269);
            t_enc(m, 1'b0, "R2 R7 R8 random");
            t_dec(int'(f_enc(m)), "R4 random round trip");
        end

        if (timed_out) begin
            n_checks++;
            n_err++;
            $display("FAIL R11 watchdog expired actual=%0d expected<%0d", cycle_cnt, WD_LIMIT);
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule